// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between software-loaded transmit mailboxes and a CAN frame transmitter. Each mailbox stores an 11-bit identifier and a pending flag. Software arms a mailbox by pulsing its request strobe with the identifier on the matching slice of the identifier bus. Whenever the transmitter is idle and at least one mailbox is pending, the scheduler picks one mailbox, pulses a start strobe, and holds the chosen mailbox index and identifier steady until the transmitter returns a completion status.

Two run-time inputs shape the behaviour. The ordering input chooses between identifier priority and request order. In identifier priority the numerically lowest identifier wins, and the lower mailbox index breaks a tie. In request order the mailbox armed earliest wins. The single-shot input decides what happens after a failed attempt: the frame is either left pending for an automatic retry, or dropped after that one attempt. Per-mailbox completion and success flags report the outcome of the most recent frame.

Top module: `can_tx_sched`

## Requirements
- R1: A request strobe on a mailbox that is not pending captures its identifier and sets its pending flag at the next edge. The same strobe clears that mailbox's completion and success flags. A strobe on a mailbox that is already pending is ignored, and the stored identifier is kept.
- R2: With `order_by_req`=0, the selected mailbox is the pending one with the numerically lowest identifier. On equal identifiers, the lower mailbox index is selected.
- R3: With `order_by_req`=1, pending mailboxes are selected in the order their requests were accepted. Requests accepted at the same edge count as made in ascending index order.
- R4: Selection happens only while `tx_busy`=0. On the edge after a mailbox is pending with the scheduler idle, `tx_start` pulses for one cycle and `tx_busy` rises. `tx_mb` and `tx_id` then stay constant until completion.
- R5: A completion with `done_status`=2'b00 (success) while busy clears the mailbox's pending flag and sets its completion and success flags at the next edge. `tx_busy` falls at that same edge.
- R6: With `single_shot`=0, a completion with status 2'b01 (error), 2'b10 (arbitration lost) or 2'b11 (treated as error) leaves the mailbox pending and its flags unchanged, so it competes again in the next selection.
- R7: With `single_shot`=1, a failed completion clears the pending flag, sets the completion flag and leaves the success flag at 0.
- R8: `done_valid` while `tx_busy`=0 has no effect on any flag.
- R9: The ordering input is read at each selection, so a change while busy takes effect on the next choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_stb | input | NUM_MB | Per-mailbox request strobe |
| req_id | input | NUM_MB*ID_W | Identifier per mailbox, mailbox i at bits [i*ID_W +: ID_W] |
| order_by_req | input | 1 | 0: identifier priority, 1: request order |
| single_shot | input | 1 | 1: one attempt per frame |
| done_valid | input | 1 | Completion strobe from transmitter |
| done_status | input | 2 | 00 success, 01 error, 10 arbitration lost, 11 error |
| tx_start | output | 1 | One-cycle pulse when a mailbox is handed over |
| tx_busy | output | 1 | A mailbox is in flight |
| tx_mb | output | IDX_W | Index of the mailbox in flight |
| tx_id | output | ID_W | Identifier of the mailbox in flight |
| mb_pending | output | NUM_MB | Pending flags |
| mb_done | output | NUM_MB | Completion flags |
| mb_ok | output | NUM_MB | Success flags |

## Verification
The assertions check, on every cycle:
- a start only names a pending mailbox;
- the in-flight index and identifier stay put while busy;
- a failed attempt either keeps or drops the mailbox according to the single-shot input;
- a success flag never stands without its completion flag;
- an idle completion leaves the flags alone.

Whether the chosen mailbox is actually the right one under each ordering policy can only be shown by the bench's scenarios. The same holds for tie-breaking, same-edge requests, ignored re-requests and a policy switch in mid-flight. For these the bench compares against its own sequence-numbered model.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int STAT_W = 2;
  localparam logic [STAT_W-1:0] TXS_OK  = 2'b00;
  localparam logic [STAT_W-1:0] TXS_ERR = 2'b01;
  localparam logic [STAT_W-1:0] TXS_ARB = 2'b10;

  typedef enum logic {SCH_IDLE = 1'b0, SCH_BUSY = 1'b1} sch_state_e;
endpackage

// File: rtl/can_tx_mbox.sv
module can_tx_mbox #(
  parameter int ID_W  = 11,
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             shift_i,
  input  logic             finish_i,
  input  logic             ok_i,
  output logic             pending_o,
  output logic [ID_W-1:0]  id_o,
  output logic [POS_W-1:0] pos_o,
  output logic             done_o,
  output logic             ok_o
);
  logic             pend_q, pend_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             done_q, done_d;
  logic             ok_q, ok_d;
  logic             flag_en, pos_en;

  assign flag_en = load_i | finish_i;
  assign pos_en  = load_i | shift_i;

  always_comb begin
    pend_d = pend_q;
    done_d = done_q;
    ok_d   = ok_q;
    id_d   = id_q;
    pos_d  = pos_q;
    if (load_i) begin
      pend_d = 1'b1;
      done_d = 1'b0;
      ok_d   = 1'b0;
      id_d   = id_i;
      pos_d  = pos_i;
    end else begin
      if (finish_i) begin
        pend_d = 1'b0;
        done_d = 1'b1;
        ok_d   = ok_i;
      end
      if (shift_i) pos_d = pos_q - POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (flag_en) begin
      pend_q <= pend_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (load_i) begin
      id_q <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign pending_o = pend_q;
  assign id_o      = id_q;
  assign pos_o     = pos_q;
  assign done_o    = done_q;
  assign ok_o      = ok_q;

  // R1: an accepted request arms the mailbox with its identifier, flags cleared
  assert_load_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pend_q && (id_q == $past(id_i)) && !done_q && !ok_q));

  // R5: success is only ever reported together with completion
  assert_ok_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> done_q);
endmodule

// File: rtl/can_tx_pick.sv
module can_tx_pick #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int POS_W  = 2,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_MB-1:0]       pending_i,
  input  logic [NUM_MB*ID_W-1:0]  ids_i,
  input  logic [NUM_MB*POS_W-1:0] pos_i,
  input  logic                    order_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        win_o
);
  logic [ID_W-1:0]  id_a  [NUM_MB];
  logic [POS_W-1:0] pos_a [NUM_MB];

  for (genvar g = 0; g < NUM_MB; g++) begin : g_unpack
    assign id_a[g]  = ids_i[g*ID_W +: ID_W];
    assign pos_a[g] = pos_i[g*POS_W +: POS_W];
  end

  logic [ID_W-1:0]  best_id;
  logic [POS_W-1:0] best_pos;
  logic             found;

  // Linear scan: a later index replaces the current best only when strictly better,
  // so equal identifiers leave the lower index in place.
  always_comb begin
    found    = 1'b0;
    win_o    = '0;
    best_id  = '0;
    best_pos = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pending_i[i]) begin
        if (!found || (order_i ? (pos_a[i] < best_pos) : (id_a[i] < best_id))) begin
          found    = 1'b1;
          win_o    = IDX_W'(i);
          best_id  = id_a[i];
          best_pos = pos_a[i];
        end
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int POS_W = IDX_W,
  localparam int CNT_W = $clog2(NUM_MB + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MB-1:0]      req_stb,
  input  logic [NUM_MB*ID_W-1:0] req_id,
  input  logic                   order_by_req,
  input  logic                   single_shot,
  input  logic                   done_valid,
  input  logic [1:0]             done_status,
  output logic                   tx_start,
  output logic                   tx_busy,
  output logic [IDX_W-1:0]       tx_mb,
  output logic [ID_W-1:0]        tx_id,
  output logic [NUM_MB-1:0]      mb_pending,
  output logic [NUM_MB-1:0]      mb_done,
  output logic [NUM_MB-1:0]      mb_ok
);
  import can_tx_pkg::*;

  sch_state_e          state_q, state_d;
  logic                start_q, start_d;
  logic [IDX_W-1:0]    sel_q, sel_d;
  logic [ID_W-1:0]     txid_q, txid_d;
  logic                sel_en;

  logic [NUM_MB-1:0]       pend, accept, leave, keep, shift;
  logic [NUM_MB*ID_W-1:0]  id_flat;
  logic [NUM_MB*POS_W-1:0] pos_flat;
  logic [ID_W-1:0]         id_a   [NUM_MB];
  logic [POS_W-1:0]        pos_a  [NUM_MB];
  logic [POS_W-1:0]        pos_ld [NUM_MB];
  logic [CNT_W-1:0]        slot;
  logic                    any_pend, fire, fire_ok, fin_now;
  logic [IDX_W-1:0]        win;

  // ---------------- mailbox bank ----------------
  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    can_tx_mbox #(.ID_W(ID_W), .POS_W(POS_W)) u_mb (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept[g]),
      .id_i     (req_id[g*ID_W +: ID_W]),
      .pos_i    (pos_ld[g]),
      .shift_i  (shift[g]),
      .finish_i (leave[g]),
      .ok_i     (fire_ok),
      .pending_o(pend[g]),
      .id_o     (id_a[g]),
      .pos_o    (pos_a[g]),
      .done_o   (mb_done[g]),
      .ok_o     (mb_ok[g])
    );
    assign id_flat[g*ID_W +: ID_W]     = id_a[g];
    assign pos_flat[g*POS_W +: POS_W]  = pos_a[g];
  end

  // ---------------- selection ----------------
  can_tx_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W), .POS_W(POS_W), .IDX_W(IDX_W)) u_pick (
    .pending_i(pend),
    .ids_i    (id_flat),
    .pos_i    (pos_flat),
    .order_i  (order_by_req),
    .any_o    (any_pend),
    .win_o    (win)
  );

  // ---------------- completion decode ----------------
  assign fire    = (state_q == SCH_BUSY) && done_valid;
  assign fire_ok = (done_status == TXS_OK);
  assign fin_now = fire && (fire_ok || single_shot);

  // ---------------- queue positions for request order ----------------
  // Surviving pending mailboxes keep relative order; new arrivals go behind them.
  always_comb begin
    leave = '0;
    if (fin_now) leave[sel_q] = 1'b1;
    keep  = pend & ~leave;
    slot  = '0;
    for (int i = 0; i < NUM_MB; i++) slot = slot + CNT_W'(keep[i]);
    for (int i = 0; i < NUM_MB; i++) begin
      accept[i] = req_stb[i] & ~pend[i];
      pos_ld[i] = POS_W'(slot);
      if (accept[i]) slot = slot + CNT_W'(1);
    end
    for (int i = 0; i < NUM_MB; i++) begin
      shift[i] = keep[i] && fin_now && (pos_a[i] > pos_a[sel_q]);
    end
  end

  // ---------------- control FSM ----------------
  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    sel_d   = sel_q;
    txid_d  = txid_q;
    unique case (state_q)
      SCH_IDLE: begin
        if (any_pend) begin
          state_d = SCH_BUSY;
          start_d = 1'b1;
          sel_d   = win;
          txid_d  = id_a[win];
        end
      end
      SCH_BUSY: begin
        if (done_valid) state_d = SCH_IDLE;
      end
      default: state_d = SCH_IDLE;
    endcase
  end

  assign sel_en = (state_q == SCH_IDLE) && any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      txid_q <= '0;
    end else if (sel_en) begin
      sel_q  <= sel_d;
      txid_q <= txid_d;
    end
  end

  assign tx_start   = start_q;
  assign tx_busy    = (state_q == SCH_BUSY);
  assign tx_mb      = sel_q;
  assign tx_id      = txid_q;
  assign mb_pending = pend;

  // R4: a start always hands over a mailbox that is pending
  assert_start_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_busy && pend[tx_mb]));

  // R4: the in-flight choice is held until completion
  assert_hold_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_start) |-> ($stable(tx_mb) && $stable(tx_id)));

  // R6: a failed attempt with retries enabled keeps the mailbox pending
  assert_retry_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && done_valid && (done_status != TXS_OK) && !single_shot)
      |=> (pend[$past(tx_mb)] && !tx_busy));

  // R7: a failed single-shot attempt drops the frame without success
  assert_single_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && done_valid && (done_status != TXS_OK) && single_shot)
      |=> (!pend[$past(tx_mb)] && mb_done[$past(tx_mb)] && !mb_ok[$past(tx_mb)]));

  // R8: a completion strobe while idle leaves every flag alone
  assert_idle_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && done_valid && (req_stb == '0)) |=> ($stable(mb_done) && $stable(mb_ok)));
endmodule

// File: tb/can_tx_sched_tb.sv
module can_tx_sched_tb;
  localparam int N  = 3;
  localparam int IW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_stb;
  logic [N*IW-1:0] req_id;
  logic          order_by_req, single_shot, done_valid;
  logic [1:0]    done_status;
  logic          tx_start, tx_busy;
  logic [1:0]    tx_mb;
  logic [IW-1:0] tx_id;
  logic [N-1:0]  mb_pending, mb_done, mb_ok;

  always #4 clk = ~clk;  // 125 MHz

  can_tx_sched #(.NUM_MB(N), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_id(req_id),
    .order_by_req(order_by_req), .single_shot(single_shot),
    .done_valid(done_valid), .done_status(done_status),
    .tx_start(tx_start), .tx_busy(tx_busy), .tx_mb(tx_mb), .tx_id(tx_id),
    .mb_pending(mb_pending), .mb_done(mb_done), .mb_ok(mb_ok)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // model state
  bit          m_pend [N];
  bit          m_done [N];
  bit          m_ok   [N];
  int          m_id   [N];
  int          m_seq  [N];
  int          seqctr = 0;
  bit          m_busy = 0, m_start = 0;
  int          m_sel = 0, m_txid = 0;

  task automatic chk(string tag, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL [%s] %s actual=%0h expected=%0h at %0t", tag, req, act, exp, $time);
    end
  endtask

  function automatic int pick(bit pol);
    int best = -1;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i]) begin
        if (best < 0) best = i;
        else if (pol ? (m_seq[i] < m_seq[best]) : (m_id[i] < m_id[best])) best = i;
      end
    end
    return best;
  endfunction

  function automatic int vec(bit v [N]);
    int r = 0;
    for (int i = 0; i < N; i++) if (v[i]) r |= (1 << i);
    return r;
  endfunction

  // Apply one edge worth of stimulus to the model, then step and compare.
  task automatic cyc(string tag, bit [N-1:0] stb, int i0, int i1, int i2, bit dv, bit [1:0] st);
    bit old_p [N];
    int ids [N];
    int fin_mb;
    bit fin_ok;
    ids[0] = i0; ids[1] = i1; ids[2] = i2;
    req_stb     = stb;
    req_id      = {IW'(i2), IW'(i1), IW'(i0)};
    done_valid  = dv;
    done_status = st;
    old_p = m_pend;
    fin_mb = -1; fin_ok = 0;
    m_start = 0;
    if (!m_busy) begin
      int w = pick(order_by_req);
      if (w >= 0) begin
        m_busy = 1; m_start = 1; m_sel = w; m_txid = m_id[w];
      end
    end else if (dv) begin
      m_busy = 0;
      if (st == 2'b00 || single_shot) begin
        fin_mb = m_sel; fin_ok = (st == 2'b00);
      end
    end
    if (fin_mb >= 0) begin
      m_pend[fin_mb] = 0; m_done[fin_mb] = 1; m_ok[fin_mb] = fin_ok;
    end
    for (int i = 0; i < N; i++) begin
      if (stb[i] && !old_p[i]) begin
        m_pend[i] = 1; m_done[i] = 0; m_ok[i] = 0;
        m_id[i] = ids[i] & 32'h7FF; m_seq[i] = seqctr; seqctr++;
      end
    end
    @(negedge clk);
    chk(tag, "R1/R6 pending", int'(mb_pending), vec(m_pend));
    chk(tag, "R7 done", int'(mb_done), vec(m_done));
    chk(tag, "R5 ok", int'(mb_ok), vec(m_ok));
    chk(tag, "R4 start", int'(tx_start), int'(m_start));
    chk(tag, "R4 busy", int'(tx_busy), int'(m_busy));
    if (m_busy) begin
      chk(tag, order_by_req ? "R3 mailbox" : "R2 mailbox", int'(tx_mb), m_sel);
      chk(tag, "R1 id", int'(tx_id), m_txid);
    end
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) cyc(tag, '0, 0, 0, 0, 1'b0, 2'b00);
  endtask

  task automatic done(string tag, bit [1:0] st);
    cyc(tag, '0, 0, 0, 0, 1'b1, st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_pend[i] = 0; m_done[i] = 0; m_ok[i] = 0; m_id[i] = 0; m_seq[i] = 0;
    end
    rst_n = 1'b0; req_stb = '0; req_id = '0; order_by_req = 0; single_shot = 0;
    done_valid = 0; done_status = 2'b00;
    repeat (3) @(negedge clk);
    chk("RST", "R4 reset busy", int'(tx_busy), 0);
    chk("RST", "R4 reset start", int'(tx_start), 0);
    chk("RST", "R1 reset pending", int'(mb_pending), 0);
    chk("RST", "R5 reset flags", int'({mb_done, mb_ok}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: identifier priority with a tie (mb1 and mb2 equal, mb1 wins)
    cyc("R2", 3'b111, 11'h300, 11'h100, 11'h100, 0, 0);
    idle("R2", 2); done("R2", 2'b00);
    idle("R2", 2); done("R2", 2'b00);
    idle("R2", 2); done("R2", 2'b00);
    idle("R2", 2);

    // R3: request order beats identifier order
    order_by_req = 1;
    cyc("R3", 3'b100, 0, 0, 11'h7FF, 0, 0);
    cyc("R3", 3'b001, 11'h500, 0, 0, 0, 0);
    cyc("R3", 3'b010, 0, 11'h001, 0, 0, 0);
    done("R3", 2'b00); idle("R3", 1);
    done("R3", 2'b00); idle("R3", 1);
    done("R3", 2'b00); idle("R3", 2);

    // R6: error and arbitration loss with retries enabled
    order_by_req = 0; single_shot = 0;
    cyc("R6", 3'b001, 11'h040, 0, 0, 0, 0);
    idle("R6", 1); done("R6", 2'b01);
    idle("R6", 1); done("R6", 2'b10);
    idle("R6", 1); done("R6", 2'b11);
    idle("R6", 1); done("R6", 2'b00);
    idle("R6", 1);

    // R7: single shot drops failures
    single_shot = 1;
    cyc("R7", 3'b011, 11'h010, 11'h020, 0, 0, 0);
    idle("R7", 1); done("R7", 2'b10);
    idle("R7", 1); done("R7", 2'b01);
    idle("R7", 2);

    // R8: completion strobe while idle
    done("R8", 2'b00); done("R8", 2'b01); idle("R8", 1);

    // R1: re-request of a pending mailbox keeps the old identifier
    single_shot = 0;
    cyc("R1", 3'b001, 11'h123, 0, 0, 0, 0);
    cyc("R1", 3'b001, 11'h001, 0, 0, 0, 0);
    idle("R1", 1); done("R1", 2'b01);
    idle("R1", 1); done("R1", 2'b00); idle("R1", 1);

    // R9: policy switch while busy applies to the next choice
    order_by_req = 0;
    cyc("R9", 3'b001, 11'h200, 0, 0, 0, 0);
    cyc("R9", 3'b100, 0, 0, 11'h300, 0, 0);
    cyc("R9", 3'b010, 0, 11'h100, 0, 0, 0);
    order_by_req = 1;
    done("R9", 2'b00); idle("R9", 1);
    done("R9", 2'b00); idle("R9", 1);
    done("R9", 2'b00); idle("R9", 2);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit [N-1:0] stb;
      bit dv;
      if (($urandom % 50) == 0) order_by_req = ~order_by_req;
      if (($urandom % 50) == 0) single_shot = ~single_shot;
      stb = (($urandom % 3) == 0) ? N'($urandom) : '0;
      dv  = m_busy ? (($urandom % 3) == 0) : (($urandom % 20) == 0);
      cyc("RND", stb,
          (($urandom % 4) == 0) ? int'($urandom % 2048) : int'($urandom % 4),
          (($urandom % 4) == 0) ? int'($urandom % 2048) : int'($urandom % 4),
          (($urandom % 4) == 0) ? int'($urandom % 2048) : int'($urandom % 4),
          dv, 2'($urandom));
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule